// File: doc/BRIEF.md
# I2S to Simultaneous-Format Converter

This block receives a two-channel I2S stream and re-serialises it for a multibit converter that expects separate left and right data lines. On the I2S side, the left and right words arrive one after the other. On the output side, both words leave on two lines that are bit-aligned with each other, and a single latch pulse then loads both channels at once.

The whole block runs on the incoming bit clock. The completed left word is parked in a holding register. When the matching right word completes, both words are loaded into two output shifters and sent during the next frame, so the latency is one frame. The output clock is the bit clock itself. Output data changes only just after a rising edge, which keeps it stable at the falling edge where the downstream converter captures it.

A frame-length monitor raises a one-cycle error flag whenever word select toggles after a half-frame of the wrong length.

Top module: `i2s_simul_conv`

## Requirements
- R1: `wsIn` and `sdIn` are sampled on rising edges of `clk`. `wsIn` low selects the left channel and high selects the right channel. Each word is 16 bits, most significant bit first. Its MSB occupies the slot one period after the `wsIn` change, and its LSB occupies the slot in which `wsIn` next changes.
- R2: The left word is captured into a holding register at the edge where `wsIn` is first seen high. It is kept there until the right word that follows it completes.
- R3: At the edge where `wsIn` is first seen low, and a held left word exists, both words are loaded. `sdLeft` and `sdRight` show their MSBs right after that same rising edge and then advance one bit per rising edge, bit-aligned. `outClk` equals `clk`, so output data changes only after rising edges.
- R4: After the 16th bit, `sdLeft` and `sdRight` stay low until the next load.
- R5: `latchOut` goes high at the rising edge 16 edges after the load, which is the edge after the LSB was presented. It stays high for exactly one bit-clock period, and both data lines are low while it is high.
- R6: Exactly one latch pulse follows each load, and `latchOut` is low at all other times.
- R7: The first `wsIn` toggle after reset captures nothing. A right word that completes with no held left word is discarded, with no output bits and no latch.
- R8: `frameErr` is high for the cycle after a `wsIn` toggle whose preceding half-frame lasted a number of bit-clock periods other than 16. The first toggle after reset never flags.
- R9: While `rstN` is low at a rising edge, all shift and holding registers clear, and `sdLeft`, `sdRight`, `latchOut` and `frameErr` are low after that edge.
- R10: Words are two's complement and pass unchanged, including 0x8000, 0x7FFF, 0xFFFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I2S bit clock; clocks the whole block |
| rstN | input | 1 | Active-low synchronous reset |
| wsIn | input | 1 | I2S word select (0 left, 1 right) |
| sdIn | input | 1 | I2S serial data |
| outClk | output | 1 | Output bit clock (same as clk) |
| sdLeft | output | 1 | Left-channel serial data, MSB first |
| sdRight | output | 1 | Right-channel serial data, MSB first |
| latchOut | output | 1 | Common latch pulse after the LSB |
| frameErr | output | 1 | One-cycle flag for a half-frame of wrong length |

## Verification
Several properties are checked on every cycle. The latch pulse lasts one period, and both data lines are low whenever it is high. Reset clears every output. An error flag appears only right after a word-select toggle.

Other behaviour depends on a sequence of frames, so only the bench scenarios can show it. These include correct pairing of left and right words, one frame of latency, MSB-first order, and the extreme two's complement values. They also cover discarding a right word that has no partner after reset, and flagging a short half-frame.

// File: rtl/i2s_simul_pkg.sv
package i2s_simul_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic captureLeft;  // park the just-completed left word
    logic loadOut;      // load both output shifters
  } dpStrobe_t;

  localparam int NUM_CHAN = 2;

endpackage

// File: rtl/i2s_simul_ctrl.sv
module i2s_simul_ctrl #(
  parameter int WORD_W     = 16,
  parameter int FRAME_BITS = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wsIn,
  output i2s_simul_pkg::dpStrobe_t strobe,
  output logic                     latchOut,
  output logic                     frameErr
);
  localparam int HALF_BITS = FRAME_BITS / 2;
  localparam int CNT_W     = $clog2(FRAME_BITS + 1);
  localparam int OUT_W     = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] HALF_VAL = CNT_W'(HALF_BITS);
  localparam logic [OUT_W-1:0] LAST_BIT = OUT_W'(WORD_W);
  localparam logic [OUT_W-1:0] OUT_ONE  = OUT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {PH_WAIT, PH_SHIFT, PH_LATCH} outPhase_t;

  logic             wsPrev;
  logic             seenToggle;
  logic             leftValid;
  logic [CNT_W-1:0] halfCnt;
  logic [OUT_W-1:0] outCnt;
  outPhase_t        phase;
  logic             wsEdge;
  logic             doCapture;
  logic             doLoad;

  assign wsEdge    = wsIn ^ wsPrev;
  assign doCapture = wsEdge && wsIn && seenToggle;
  assign doLoad    = wsEdge && !wsIn && leftValid;

  always_comb begin
    strobe             = '0;
    strobe.captureLeft = doCapture;
    strobe.loadOut     = doLoad;
  end

  // word-select tracking and frame-length monitor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wsPrev     <= 1'b0;
      seenToggle <= 1'b0;
      halfCnt    <= '0;
      frameErr   <= 1'b0;
    end else begin
      wsPrev   <= wsIn;
      frameErr <= wsEdge && seenToggle && (halfCnt != HALF_VAL);
      if (wsEdge) begin
        seenToggle <= 1'b1;
        halfCnt    <= CNT_ONE;
      end else if (halfCnt != CNT_MAX) begin
        halfCnt <= halfCnt + CNT_ONE;
      end
    end
  end

  // pairing state: a left word waits for its right partner
  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftValid <= 1'b0;
    end else if (doCapture) begin
      leftValid <= 1'b1;
    end else if (doLoad) begin
      leftValid <= 1'b0;
    end
  end

  // output sequencing: shift phase, then one latch period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt   <= '0;
      phase    <= PH_WAIT;
      latchOut <= 1'b0;
    end else if (doLoad) begin
      outCnt   <= OUT_ONE;
      phase    <= PH_SHIFT;
      latchOut <= 1'b0;
    end else begin
      case (phase)
        PH_SHIFT: begin
          if (outCnt == LAST_BIT) begin
            outCnt   <= '0;
            phase    <= PH_LATCH;
            latchOut <= 1'b1;
          end else begin
            outCnt   <= outCnt + OUT_ONE;
            latchOut <= 1'b0;
          end
        end
        PH_LATCH: begin
          phase    <= PH_WAIT;
          latchOut <= 1'b0;
        end
        default: begin
          phase    <= PH_WAIT;
          latchOut <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2s_simul_datapath.sv
module i2s_simul_datapath #(
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sdIn,
  input  i2s_simul_pkg::dpStrobe_t strobe,
  output logic                     sdLeftOut,
  output logic                     sdRightOut
);
  localparam int NCH = i2s_simul_pkg::NUM_CHAN;

  logic [WORD_W-1:0] inShift;
  logic [WORD_W-1:0] newWord;
  logic [WORD_W-1:0] leftHold;
  logic [NCH-1:0]    chanBit;

  assign newWord = {inShift[WORD_W-2:0], sdIn};

  // input deserialiser: last WORD_W sampled bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
    end else begin
      inShift <= newWord;
    end
  end

  // left-word holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftHold <= '0;
    end else if (strobe.captureLeft) begin
      leftHold <= newWord;
    end
  end

  // one output shifter per channel, zero-filled so the line idles low
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [WORD_W-1:0] shReg;
    logic [WORD_W-1:0] loadVal;
    assign loadVal = (ch == 0) ? leftHold : newWord;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg <= '0;
      end else if (strobe.loadOut) begin
        shReg <= loadVal;
      end else begin
        shReg <= {shReg[WORD_W-2:0], 1'b0};
      end
    end
    assign chanBit[ch] = shReg[WORD_W-1];
  end

  assign sdLeftOut  = chanBit[0];
  assign sdRightOut = chanBit[1];

endmodule

// File: rtl/i2s_simul_conv.sv
module i2s_simul_conv #(
  parameter int WORD_W     = 16,
  parameter int FRAME_BITS = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic wsIn,
  input  logic sdIn,
  output logic outClk,
  output logic sdLeft,
  output logic sdRight,
  output logic latchOut,
  output logic frameErr
);
  i2s_simul_pkg::dpStrobe_t strobe;

  assign outClk = clk;

  i2s_simul_ctrl #(.WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wsIn     (wsIn),
    .strobe   (strobe),
    .latchOut (latchOut),
    .frameErr (frameErr)
  );

  i2s_simul_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdIn       (sdIn),
    .strobe     (strobe),
    .sdLeftOut  (sdLeft),
    .sdRightOut (sdRight)
  );

endmodule

// File: rtl/i2s_simul_conv_checker.sv
module i2s_simul_conv_checker (
  input logic clk,
  input logic rstN,
  input logic wsIn,
  input logic sdLeft,
  input logic sdRight,
  input logic latchOut,
  input logic frameErr
);
  // R5: latch lasts exactly one period
  assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    latchOut |=> !latchOut);

  // R4: both data lines quiet while the latch is high
  assert_lines_low_at_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    latchOut |-> (!sdLeft && !sdRight));

  // R9: a reset edge clears every output
  assert_reset_clears_R9: assert property (@(posedge clk)
    !rstN |=> (!sdLeft && !sdRight && !latchOut && !frameErr));

  // R8: an error flag only follows a word-select toggle
  assert_err_after_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> ($past(wsIn) != $past(wsIn, 2)));

endmodule

bind i2s_simul_conv i2s_simul_conv_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wsIn     (wsIn),
  .sdLeft   (sdLeft),
  .sdRight  (sdRight),
  .latchOut (latchOut),
  .frameErr (frameErr)
);

// File: tb/i2s_simul_conv_bench.sv
`timescale 1ns/1ps
module i2s_simul_conv_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wsIn = 1'b0;
  logic sdIn = 1'b0;
  logic outClk, sdLeft, sdRight, latchOut, frameErr;

  always #2.5 clk = ~clk;

  i2s_simul_conv u_i2s_simul_conv (
    .clk(clk), .rstN(rstN), .wsIn(wsIn), .sdIn(sdIn), .outClk(outClk),
    .sdLeft(sdLeft), .sdRight(sdRight), .latchOut(latchOut), .frameErr(frameErr)
  );

  int checks = 0;
  int failed = 0;
  bit done = 0;

  // behavioural reference state
  bit        qIn[$];
  bit        expLq[$];
  bit        expRq[$];
  bit        mPrevWs, mSeen, mLeftValid;
  int        mHalfLen, mLatchIn;
  logic [15:0] mLeftWord;
  bit        eL, eR, eLat, eErr;

  // end-to-end tracking
  logic [31:0] pairQ[$];
  logic [15:0] capL, capR, prevRight;
  bit        tracking;
  int        latchCount, expectedLoads, errSeen;

  task automatic modelReset();
    qIn.delete();
    for (int i = 0; i < 16; i++) qIn.push_back(1'b0);
    expLq.delete(); expRq.delete();
    mPrevWs = 0; mSeen = 0; mLeftValid = 0; mHalfLen = 0; mLatchIn = 0;
    mLeftWord = '0; eL = 0; eR = 0; eLat = 0; eErr = 0;
  endtask

  task automatic modelStep();
    bit edgeSeen, doLoad, doCap;
    logic [15:0] w;
    if (!rstN) begin
      modelReset();
      return;
    end
    edgeSeen = (wsIn != mPrevWs);
    qIn.push_back(sdIn);
    if (qIn.size() > 16) void'(qIn.pop_front());
    w = '0;
    foreach (qIn[i]) w = {w[14:0], qIn[i]};
    eErr = edgeSeen && mSeen && (mHalfLen != 16);
    if (edgeSeen) mHalfLen = 1; else if (mHalfLen < 1000) mHalfLen++;
    doCap  = edgeSeen && wsIn && mSeen;
    doLoad = edgeSeen && !wsIn && mLeftValid;
    if (edgeSeen) mSeen = 1;
    if (doCap) begin mLeftWord = w; mLeftValid = 1; end
    if (doLoad) begin
      mLeftValid = 0;
      expLq.delete(); expRq.delete();
      for (int b = 15; b >= 0; b--) begin
        expLq.push_back(mLeftWord[b]);
        expRq.push_back(w[b]);
      end
      mLatchIn = 16;
      eLat = 0;
    end else if (mLatchIn > 0) begin
      mLatchIn--;
      eLat = (mLatchIn == 0);
    end else begin
      eLat = 0;
    end
    if (expLq.size() > 0) begin
      eL = expLq.pop_front();
      eR = expRq.pop_front();
    end else begin
      eL = 0; eR = 0;
    end
    mPrevWs = wsIn;
  endtask

  task automatic tick();
    logic [31:0] pr;
    @(negedge clk);
    modelStep();
    checks++;
    if (sdLeft !== eL || sdRight !== eR) begin
      failed++;
      $display("FAIL R3 data lines actual %b%b expected %b%b at %0t", sdLeft, sdRight, eL, eR, $time);
    end
    checks++;
    if (latchOut !== eLat) begin
      failed++;
      $display("FAIL R5 latch actual %b expected %b at %0t", latchOut, eLat, $time);
    end
    checks++;
    if (frameErr !== eErr) begin
      failed++;
      $display("FAIL R8 frameErr actual %b expected %b at %0t", frameErr, eErr, $time);
    end
    if (frameErr === 1'b1) errSeen++;
    if (tracking && latchOut === 1'b1) begin
      latchCount++;
      checks++;
      if (sdLeft !== 1'b0 || sdRight !== 1'b0) begin
        failed++;
        $display("FAIL R4 lines during latch actual %b%b expected 00", sdLeft, sdRight);
      end
      checks++;
      if (pairQ.size() == 0) begin
        failed++;
        $display("FAIL R6 latch without pending pair actual 1 expected 0");
      end else begin
        pr = pairQ.pop_front();
        if ({capL, capR} !== pr) begin
          failed++;
          $display("FAIL R1/R2/R10 words actual %h/%h expected %h/%h", capL, capR, pr[31:16], pr[15:0]);
        end
      end
    end
    capL = {capL[14:0], sdLeft};
    capR = {capR[14:0], sdRight};
  endtask

  task automatic bitOut(input bit wsv, input bit sdv);
    wsIn = wsv;
    sdIn = sdv;
    tick();
  endtask

  task automatic sendFrame(input logic [15:0] l, input logic [15:0] r, input bit keep);
    bitOut(1'b0, prevRight[0]);
    for (int s = 1; s < 16; s++) bitOut(1'b0, l[16-s]);
    bitOut(1'b1, l[0]);
    for (int s = 1; s < 16; s++) bitOut(1'b1, r[16-s]);
    prevRight = r;
    if (keep) begin
      pairQ.push_back({l, r});
      expectedLoads++;
    end
  endtask

  task automatic expectBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failed++;
      $display("FAIL R6 watchdog expired actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, failed);
      $finish;
    end
  end

  initial begin
    modelReset();
    capL = '0; capR = '0; prevRight = '0;
    tracking = 0; latchCount = 0; expectedLoads = 0; errSeen = 0;

    // R9: reset state
    rstN = 1'b0;
    repeat (4) tick();
    expectBit("R9 sdLeft after reset", sdLeft, 1'b0);
    expectBit("R9 sdRight after reset", sdRight, 1'b0);
    expectBit("R9 latch after reset", latchOut, 1'b0);
    expectBit("R9 frameErr after reset", frameErr, 1'b0);
    rstN = 1'b1;
    tracking = 1;

    // R7: partial prefix, first toggle, unpaired right word
    for (int i = 0; i < 5; i++) bitOut(1'b0, 1'($urandom));
    sendFrame(16'h1111, 16'h2222, 1'b0);
    sendFrame(16'h8000, 16'h7FFF, 1'b1);
    checks++;
    if (latchCount != 0) begin
      failed++;
      $display("FAIL R7 latch count before first pair actual %0d expected 0", latchCount);
    end

    // R10 extremes and assorted patterns
    sendFrame(16'h7FFF, 16'h8000, 1'b1);
    sendFrame(16'hFFFF, 16'h0000, 1'b1);
    sendFrame(16'h1234, 16'hABCD, 1'b1);
    sendFrame(16'h0001, 16'hFFFE, 1'b1);
    for (int f = 0; f < 6; f++) begin
      logic [31:0] rv;
      rv = $urandom;
      sendFrame(rv[31:16], rv[15:0], 1'b1);
    end
    // flush: the fall loads the last pair, then wait past its latch
    bitOut(1'b0, prevRight[0]);
    for (int i = 0; i < 20; i++) bitOut(1'b0, 1'b0);

    checks++;
    if (latchCount != expectedLoads) begin
      failed++;
      $display("FAIL R6 latch count actual %0d expected %0d", latchCount, expectedLoads);
    end
    checks++;
    if (pairQ.size() != 0) begin
      failed++;
      $display("FAIL R3 pairs left unsent actual %0d expected 0", pairQ.size());
    end
    checks++;
    if (errSeen != 0) begin
      failed++;
      $display("FAIL R8 errors on good frames actual %0d expected 0", errSeen);
    end
    expectBit("R4 idle sdLeft", sdLeft, 1'b0);
    expectBit("R4 idle sdRight", sdRight, 1'b0);

    // R8: short half-frame
    tracking = 0;
    for (int i = 0; i < 16; i++) bitOut(1'b1, 1'b0);
    bitOut(1'b0, 1'b0);
    expectBit("R8 no error after 16-slot half", frameErr, 1'b0);
    for (int i = 1; i < 12; i++) bitOut(1'b0, 1'b1);
    bitOut(1'b1, 1'b0);
    expectBit("R8 error after 12-slot half", frameErr, 1'b1);
    bitOut(1'b1, 1'b0);
    expectBit("R8 error is one cycle", frameErr, 1'b0);
    for (int i = 2; i < 16; i++) bitOut(1'b1, 1'b0);

    // R9: reset in the middle of shifting
    sendFrame(16'hFFFF, 16'hFFFF, 1'b0);
    sendFrame(16'hFFFF, 16'hFFFF, 1'b0);
    bitOut(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) bitOut(1'b0, 1'b1);
    expectBit("R3 shifting before reset", sdLeft, 1'b1);
    rstN = 1'b0;
    tick();
    tick();
    expectBit("R9 sdLeft cleared mid-word", sdLeft, 1'b0);
    expectBit("R9 sdRight cleared mid-word", sdRight, 1'b0);
    expectBit("R9 latch cleared mid-word", latchOut, 1'b0);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) bitOut(1'b0, 1'b1);
    expectBit("R7 no output without pair after reset", sdLeft, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, failed);
    $finish;
  end

endmodule